// File: doc/BRIEF.md
# Page Write-Protect Checker

This block watches each bus cycle aimed at a one-megaword physical memory and reports accesses that must not proceed. Memory is split into 1024 pages of 1K words. Every page carries two write-protect bits, one that applies when the processor writes and one that applies when a DMA master writes, so the two kinds of master can be given different rights to the same page. The block also reports memory accesses that fall into a 64K-word block marked as absent, and I/O accesses that fall into a 4K-address I/O group marked as illegal.

Software programs the tables through a small register port: one selector picks the page table, the block map, the I/O group map or the control word, an index picks the entry, and two data bits give the value. A bus cycle is presented with a strobe, the 20-bit address, a write qualifier, a master-type bit and an I/O-versus-memory bit. One cycle later the block raises a one-cycle error pulse with a cause vector, and it keeps a sticky error bit until software clears it.

Top module: `wpc_top`

## Requirements
- R1: After reset every protect bit is clear, every memory block is implemented, every I/O group is legal, detection of illegal addresses is enabled, and err_pulse, err_kind and err_sticky are all zero.
- R2: The page of a memory access is bus_addr[19:10]; bus_addr[9:0] has no effect on the protection result.
- R3: A memory write by the processor (bus_dma=0) to a page whose processor protect bit is set raises err_pulse with err_kind bit 0 set.
- R4: A memory write by a DMA master (bus_dma=1) is checked only against the page's DMA protect bit; the processor bit has no effect on it, and the DMA bit has no effect on processor writes.
- R5: A memory read never sets err_kind bit 0.
- R6: While detection is enabled, any memory access (read or write) whose block bus_addr[19:16] is marked absent raises err_pulse with err_kind bit 1 set.
- R7: While detection is enabled, any I/O access whose group bus_addr[15:12] is marked illegal raises err_pulse with err_kind bit 2 set; I/O accesses are never checked against the page protect bits.
- R8: With detection disabled, err_kind bits 1 and 2 stay zero, while protection errors are still reported.
- R9: err_pulse is high exactly in the cycle after the strobed cycle that caused it, for one cycle, and is low after a cycle without strobe.
- R10: err_sticky is set by any error and held until a control write with cfg_wdata[1]=1; an error in the same cycle as that clear leaves it set.
- R11: Register port: cfg_sel=0 writes page cfg_idx with cfg_wdata[0]=processor protect and cfg_wdata[1]=DMA protect; cfg_sel=1 writes block cfg_idx[3:0] with cfg_wdata[0]=1 meaning implemented; cfg_sel=2 writes I/O group cfg_idx[3:0] with cfg_wdata[0]=1 meaning legal; cfg_sel=3 sets the detection enable from cfg_wdata[0] and clears the sticky bit when cfg_wdata[1]=1. A table write applies to bus cycles from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (page, block, I/O group, control) |
| cfg_idx | input | 10 | Entry index |
| cfg_wdata | input | 2 | Write data |
| bus_strobe | input | 1 | Bus cycle valid |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_dma | input | 1 | 1 when a DMA master owns the cycle |
| bus_io | input | 1 | 1 for I/O space, 0 for memory |
| bus_addr | input | 20 | Physical word address |
| err_pulse | output | 1 | One-cycle error flag to the processor |
| err_kind | output | 3 | Cause: bit0 protection, bit1 absent block, bit2 illegal I/O |
| err_sticky | output | 1 | Held error status |

## Verification
The properties assume that the bus qualifiers (write, master type, I/O) are valid whenever bus_strobe is high and that the register port and the bus are only driven after reset has been released. The stimulus changes all inputs on the falling edge, holds each bus cycle for exactly one clock and returns the strobe low between phases, so every error is attributable to a single strobed cycle. Sweeps cover every page for both master types and reads, every block and every I/O group, with detection on and off.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    localparam int ADDR_W  = 20;
    localparam int OFS_W   = 10;
    localparam int PAGE_W  = ADDR_W - OFS_W;
    localparam int PAGES   = 1 << PAGE_W;
    localparam int BLK_W   = 4;
    localparam int IO_AW   = 16;
    localparam int GRP_W   = 4;
    localparam int NGROUPS = 1 << GRP_W;

    typedef enum logic [1:0] {
        SEL_PAGE  = 2'd0,
        SEL_BLOCK = 2'd1,
        SEL_IOGRP = 2'd2,
        SEL_CTRL  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic io_bad;
        logic absent;
        logic prot;
    } err_kind_t;

    function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: PAGE_W];
    endfunction

    function automatic logic [BLK_W-1:0] block_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: BLK_W];
    endfunction

    function automatic logic [GRP_W-1:0] group_of(input logic [ADDR_W-1:0] a);
        return a[IO_AW-1 -: GRP_W];
    endfunction
endpackage

// File: rtl/wpc_prot_table.sv
module wpc_prot_table #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic             wcpu,
    input  logic             wdma,
    input  logic [IDX_W-1:0] ridx,
    output logic             rd_cpu,
    output logic             rd_dma
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] cpu_bits;
    logic [DEPTH-1:0] dma_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_bits <= '0;
            dma_bits <= '0;
        end else if (we) begin
            cpu_bits[widx] <= wcpu;
            dma_bits[widx] <= wdma;
        end
    end

    assign rd_cpu = cpu_bits[ridx];
    assign rd_dma = dma_bits[ridx];
endmodule

// File: rtl/wpc_bitmap.sv
module wpc_bitmap #(
    parameter int   IDX_W     = 4,
    parameter logic RESET_BIT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic             wbit,
    input  logic [IDX_W-1:0] ridx,
    output logic             rbit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] bits;

    always_ff @(posedge clk) begin
        if (rst)
            bits <= {DEPTH{RESET_BIT}};
        else if (we)
            bits[widx] <= wbit;
    end

    assign rbit = bits[ridx];
endmodule

// File: rtl/wpc_top.sv
module wpc_top
    import wpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [PAGE_W-1:0] cfg_idx,
    input  logic [1:0]        cfg_wdata,
    input  logic              bus_strobe,
    input  logic              bus_write,
    input  logic              bus_dma,
    input  logic              bus_io,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              err_pulse,
    output logic [2:0]        err_kind,
    output logic              err_sticky
);
    cfg_sel_e  sel;
    logic      page_we, block_we, grp_we, ctrl_we, clr_req;
    logic      prot_cpu, prot_dma, blk_ok, grp_ok;
    logic      det_en;
    err_kind_t now_kind, kind_q;
    logic      any_err;

    assign sel      = cfg_sel_e'(cfg_sel);
    assign page_we  = cfg_we && (sel == SEL_PAGE);
    assign block_we = cfg_we && (sel == SEL_BLOCK);
    assign grp_we   = cfg_we && (sel == SEL_IOGRP);
    assign ctrl_we  = cfg_we && (sel == SEL_CTRL);
    assign clr_req  = ctrl_we && cfg_wdata[1];

    wpc_prot_table #(.IDX_W(PAGE_W)) u_pages (
        .clk(clk), .rst(rst), .we(page_we), .widx(cfg_idx),
        .wcpu(cfg_wdata[0]), .wdma(cfg_wdata[1]),
        .ridx(page_of(bus_addr)), .rd_cpu(prot_cpu), .rd_dma(prot_dma)
    );

    wpc_bitmap #(.IDX_W(BLK_W), .RESET_BIT(1'b1)) u_blocks (
        .clk(clk), .rst(rst), .we(block_we), .widx(cfg_idx[BLK_W-1:0]),
        .wbit(cfg_wdata[0]), .ridx(block_of(bus_addr)), .rbit(blk_ok)
    );

    wpc_bitmap #(.IDX_W(GRP_W), .RESET_BIT(1'b1)) u_groups (
        .clk(clk), .rst(rst), .we(grp_we), .widx(cfg_idx[GRP_W-1:0]),
        .wbit(cfg_wdata[0]), .ridx(group_of(bus_addr)), .rbit(grp_ok)
    );

    always_ff @(posedge clk) begin
        if (rst)
            det_en <= 1'b1;
        else if (ctrl_we)
            det_en <= cfg_wdata[0];
    end

    always_comb begin
        now_kind        = '0;
        now_kind.prot   = bus_strobe && bus_write && !bus_io &&
                          (bus_dma ? prot_dma : prot_cpu);
        now_kind.absent = bus_strobe && !bus_io && det_en && !blk_ok;
        now_kind.io_bad = bus_strobe && bus_io && det_en && !grp_ok;
    end

    assign any_err = |now_kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q     <= '0;
            err_pulse  <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            kind_q    <= now_kind;
            err_pulse <= any_err;
            if (any_err)
                err_sticky <= 1'b1;
            else if (clr_req)
                err_sticky <= 1'b0;
        end
    end

    assign err_kind = kind_q;
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [1:0] cfg_sel,
    input logic [1:0] cfg_wdata,
    input logic       bus_strobe,
    input logic       bus_write,
    input logic       bus_io,
    input logic       err_pulse,
    input logic [2:0] err_kind,
    input logic       err_sticky
);
    assert_pulse_sets_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_sticky);

    assert_sticky_holds_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(err_sticky) && !$past(cfg_we && cfg_sel == 2'd3 && cfg_wdata[1]))
        |-> err_sticky);

    assert_pulse_after_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(bus_strobe));

    assert_prot_mem_write_only_R5: assert property (@(posedge clk) disable iff (rst)
        err_kind[0] |-> $past(bus_write && !bus_io));

    assert_absent_mem_only_R6: assert property (@(posedge clk) disable iff (rst)
        err_kind[1] |-> $past(!bus_io));

    assert_iobad_io_only_R7: assert property (@(posedge clk) disable iff (rst)
        err_kind[2] |-> $past(bus_io));
endmodule

bind wpc_top wpc_checker u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_strobe(bus_strobe), .bus_write(bus_write),
    .bus_io(bus_io), .err_pulse(err_pulse), .err_kind(err_kind),
    .err_sticky(err_sticky)
);

// File: tb/sim_wpc_top.sv
`timescale 1ns/1ps
module sim_wpc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [9:0]  cfg_idx = '0;
    logic [1:0]  cfg_wdata = '0;
    logic        bus_strobe = 1'b0, bus_write = 1'b0, bus_dma = 1'b0, bus_io = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        err_pulse, err_sticky;
    logic [2:0]  err_kind;

    int tests = 0, fails = 0;
    logic m_cpu [1024];
    logic m_dma [1024];
    logic m_blk [16];
    logic m_grp [16];
    logic m_en;

    always #5 clk = ~clk;

    wpc_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .bus_strobe(bus_strobe),
        .bus_write(bus_write), .bus_dma(bus_dma), .bus_io(bus_io),
        .bus_addr(bus_addr), .err_pulse(err_pulse), .err_kind(err_kind),
        .err_sticky(err_sticky)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] s, input logic [9:0] i, input logic [1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_idx = i; cfg_wdata = d;
        case (s)
            2'd0: begin m_cpu[i] = d[0]; m_dma[i] = d[1]; end
            2'd1: m_blk[i[3:0]] = d[0];
            2'd2: m_grp[i[3:0]] = d[0];
            default: m_en = d[0];
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [2:0] model(input logic w, input logic d, input logic io,
                                         input logic [19:0] a);
        logic [2:0] k;
        k = '0;
        k[0] = w && !io && (d ? m_dma[a[19:10]] : m_cpu[a[19:10]]);
        k[1] = !io && m_en && !m_blk[a[19:16]];
        k[2] = io && m_en && !m_grp[a[15:12]];
        return k;
    endfunction

    task automatic access(input string req, input logic w, input logic d,
                          input logic io, input logic [19:0] a);
        logic [2:0] e;
        e = model(w, d, io, a);
        @(negedge clk);
        bus_strobe = 1'b1; bus_write = w; bus_dma = d; bus_io = io; bus_addr = a;
        @(negedge clk);
        bus_strobe = 1'b0;
        check(req, {29'd0, err_kind}, {29'd0, e});
        check(req, {31'd0, err_pulse}, {31'd0, |e});
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin m_cpu[i] = 0; m_dma[i] = 0; end
        for (int i = 0; i < 16; i++) begin m_blk[i] = 1; m_grp[i] = 1; end
        m_en = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", {29'd0, err_kind}, 32'd0);
        check("R1", {31'd0, err_pulse}, 32'd0);
        check("R1", {31'd0, err_sticky}, 32'd0);
        for (int p = 0; p < 1024; p += 7)
            access("R1", 1'b1, p[0], 1'b0, {p[9:0], 10'(p * 13)});
        for (int g = 0; g < 16; g++)
            access("R1", 1'b1, 1'b0, 1'b1, {4'd0, g[3:0], 12'h5a5});
        check("R1", {31'd0, err_sticky}, 32'd0);

        // R11 load page table: cpu bit on p%3==0, dma bit on p%5==1
        for (int p = 0; p < 1024; p++)
            cfg(2'd0, p[9:0], {1'(p % 5 == 1), 1'(p % 3 == 0)});
        // R2 R3 R4 R5 sweep all pages, masters and reads, varied offsets
        for (int p = 0; p < 1024; p++) begin
            access("R3", 1'b1, 1'b0, 1'b0, {p[9:0], 10'(p * 37)});
            access("R4", 1'b1, 1'b1, 1'b0, {p[9:0], 10'(1023 - p)});
            access("R5", 1'b0, p[1], 1'b0, {p[9:0], 10'(p)});
        end
        // R2 offset extremes on a protected page
        access("R2", 1'b1, 1'b0, 1'b0, {10'd3, 10'd0});
        access("R2", 1'b1, 1'b0, 1'b0, {10'd3, 10'h3ff});
        access("R2", 1'b1, 1'b0, 1'b0, {10'd4, 10'h3ff});

        // R11 a table write applies to the next access
        access("R11", 1'b1, 1'b0, 1'b0, {10'd2, 10'd9});
        cfg(2'd0, 10'd2, 2'b01);
        access("R11", 1'b1, 1'b0, 1'b0, {10'd2, 10'd9});

        // R6 blocks: odd blocks absent
        for (int b = 1; b < 16; b += 2) cfg(2'd1, 10'(b), 2'b00);
        for (int b = 0; b < 16; b++) begin
            access("R6", 1'b0, 1'b0, 1'b0, {b[3:0], 16'h0400});
            access("R6", 1'b1, 1'b1, 1'b0, {b[3:0], 16'h1c00});
        end
        // R7 I/O groups: g%3==0 illegal; page protect bits ignored
        for (int g = 0; g < 16; g += 3) cfg(2'd2, 10'(g), 2'b00);
        for (int g = 0; g < 16; g++) begin
            access("R7", 1'b1, 1'b0, 1'b1, {4'd0, g[3:0], 12'h000});
            access("R7", 1'b0, 1'b1, 1'b1, {4'd1, g[3:0], 12'hfff});
        end

        // R8 detection off
        cfg(2'd3, 10'd0, 2'b00);
        for (int b = 0; b < 16; b++) begin
            access("R8", 1'b1, 1'b0, 1'b0, {b[3:0], 16'h0000});
            access("R8", 1'b0, 1'b0, 1'b1, {4'd0, b[3:0], 12'h123});
        end
        cfg(2'd3, 10'd0, 2'b01);

        // R9 pulse lasts one cycle
        access("R9", 1'b1, 1'b0, 1'b0, {10'd0, 10'd0});
        @(negedge clk);
        check("R9", {31'd0, err_pulse}, 32'd0);

        // R10 sticky hold, clear, set-wins
        check("R10", {31'd0, err_sticky}, 32'd1);
        repeat (3) @(negedge clk);
        check("R10", {31'd0, err_sticky}, 32'd1);
        cfg(2'd3, 10'd0, 2'b11);
        check("R10", {31'd0, err_sticky}, 32'd0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 2'b11;
        bus_strobe = 1'b1; bus_write = 1'b1; bus_dma = 1'b0; bus_io = 1'b0;
        bus_addr = {10'd0, 10'd0};
        @(negedge clk);
        cfg_we = 1'b0; bus_strobe = 1'b0;
        check("R10", {31'd0, err_sticky}, 32'd1);
        check("R10", {31'd0, err_pulse}, 32'd1);
        cfg(2'd3, 10'd0, 2'b11);
        check("R10", {31'd0, err_sticky}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule